// File: doc/BRIEF.md
# Variable-Length Instruction Unpacker

The unpacker sits between instruction memory and the execute stage of a small stack machine. Code is stored as a dense run of 4-bit nibbles packed into 16-bit memory words, so one instruction can be 1, 2, 3 or 6 nibbles long. The most common stack and return-stack operations fit in one nibble. Rarer operations take a prefix nibble and a selector nibble. Short addresses and small literals take a code nibble and one operand byte. Any other address or literal takes an escape nibble, a kind nibble and a full 16-bit operand. The block takes memory words on a valid/ready input stream, holds them in a 12-nibble staging window, and presents one decoded instruction per cycle on a valid/ready output stream. Each decoded instruction is a class, an opcode and a 16-bit operand. Instructions may cross word boundaries freely.

Back-pressure works the same way on both streams. A word moves only in a cycle where both `word_valid` and `word_ready` are high. An instruction moves only in a cycle where both `out_valid` and `out_ready` are high. `word_ready` depends only on how full the window is, never on `out_ready`. A presented instruction stays unchanged until it is taken. For a jump, the control logic pulses `restart` for one cycle and places the target's nibble offset on `restart_nib`. During that cycle both streams are stalled and everything staged is dropped. The source then supplies the word that holds the target.

Top module: `instr_unpacker`

## Requirements
- R1: After reset, `out_valid` is 0 and `word_ready` is 1.
- R2: Code nibbles 0x0 to 0x8 are one-nibble operations: class 0 (short), opcode equal to the code, operand 0.
- R3: Code 0x9 is a prefix. The following nibble is the opcode of a class 1 (extended) operation, and the operand is 0. Length is 2 nibbles.
- R4: Codes 0xA, 0xB, 0xC and 0xD are short-address forms for read, write, jump and conditional jump. They give class 2 with opcodes 0, 1, 2 and 3. The next two nibbles form a byte, high nibble first, which is zero-extended to give the operand. Length is 3 nibbles.
- R5: Code 0xE is the short literal: class 3, opcode 0. The next byte is treated as b, and the operand is b minus 127 as a signed 16-bit value, so that b=0x00 gives 0xFF81 (-127) and b=0xFF gives 0x0080 (128). Length is 3 nibbles.
- R6: Code 0xF is the long form: a kind nibble k, then a 16-bit operand taken from four nibbles, most significant first. If k is 0 to 3, the result is class 2 with opcode k. Otherwise the result is class 3 with opcode 0. Length is 6 nibbles.
- R7: Within a word, nibbles are taken from bits 15:12 down to bits 3:0. Instructions follow one another with no gaps, even across word boundaries, and come out in stream order. At most one instruction leaves per cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_class`, `out_op` and `out_operand` keep their values in the next cycle, unless `restart` is high.
- R9: The window holds 12 nibbles. `word_ready` is high exactly when at most 8 nibbles are staged and `restart` is low.
- R10: While `restart` is high, `word_ready` and `out_valid` are 0. All staged nibbles are discarded. The first word accepted afterwards has its leading `restart_nib` nibbles (0 to 3) dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | 16 | Memory word holding packed nibbles |
| word_valid | input | 1 | `word_in` is offered |
| word_ready | output | 1 | A word can be taken this cycle |
| restart | input | 1 | Discard staged code and restart at a jump target |
| restart_nib | input | 2 | Nibble offset of the target inside its first word |
| out_valid | output | 1 | A complete instruction is presented |
| out_ready | input | 1 | The consumer takes the instruction this cycle |
| out_class | output | 2 | 0 short, 1 extended, 2 address, 3 literal |
| out_op | output | 4 | Opcode within the class |
| out_operand | output | 16 | Address or literal value, 0 for classes 0 and 1 |

## Verification
The decoded fields are driven combinationally from the registered window. A word taken at a clock edge can therefore complete an instruction in the cycle that starts at that edge. Taking an instruction at an edge shows the next one, and the new `word_ready`, right after that edge. `restart` clears `word_ready` and `out_valid` in its own cycle, and the effect of the cleared window appears one edge later. The bench changes inputs at the falling edge and samples 1 ns later, so every handshake is judged on the values the next rising edge will register. Expected instructions are compared in stream order, one per completed output handshake.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam int WORD_W   = 16;
  localparam int NIB_W    = 4;
  localparam int NPW      = WORD_W / NIB_W;  // nibbles per word
  localparam int MAX_LEN  = 6;               // longest instruction, nibbles
  localparam int LEN_W    = 3;
  localparam int HEAD_W   = MAX_LEN * NIB_W;

  localparam logic [3:0] CODE_SHORT_LAST = 4'h8;
  localparam logic [3:0] CODE_EXT        = 4'h9;
  localparam logic [3:0] CODE_ADDR_FIRST = 4'hA;
  localparam logic [3:0] CODE_ADDR_LAST  = 4'hD;
  localparam logic [3:0] CODE_LIT        = 4'hE;
  localparam logic [3:0] LONG_ADDR_LAST  = 4'h3;
  localparam logic [15:0] LIT_BIAS       = 16'd127;

  typedef enum logic [1:0] {
    CL_SHORT = 2'd0,
    CL_EXT   = 2'd1,
    CL_ADDR  = 2'd2,
    CL_LIT   = 2'd3
  } iclass_t;
endpackage

// File: rtl/nib_window.sv
module nib_window
  import unpk_pkg::*;
#(
  parameter int WIN_WORDS = 3,
  parameter int CW        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [1:0]        skip_in,
  input  logic              push,
  input  logic [WORD_W-1:0] word,
  input  logic [CW-1:0]     consume,
  output logic [CW-1:0]     cnt,
  output logic [HEAD_W-1:0] head
);
  localparam int NIBS = WIN_WORDS * NPW;
  localparam int W    = NIBS * NIB_W;

  // Staged nibbles sit at the top of win, oldest first; slots past cnt stay zero.
  logic [W-1:0]      win, win_n, shifted, ins;
  logic [WORD_W-1:0] word_sh;
  logic [CW-1:0]     keep, cnt_n;
  logic [1:0]        skip_q;

  always_comb begin
    keep    = cnt - consume;
    shifted = win << {consume, 2'b00};
    word_sh = word << {skip_q, 2'b00};
    ins     = {word_sh, {(W-WORD_W){1'b0}}} >> {keep, 2'b00};
    win_n   = push ? (shifted | ins) : shifted;
    cnt_n   = push ? (keep + CW'(NPW) - CW'(skip_q)) : keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win    <= '0;
      cnt    <= '0;
      skip_q <= '0;
    end else if (clear) begin
      win    <= '0;
      cnt    <= '0;
      skip_q <= skip_in;
    end else begin
      win <= win_n;
      cnt <= cnt_n;
      if (push) skip_q <= '0;
    end
  end

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_head
    assign head[HEAD_W-1-NIB_W*g -: NIB_W] = win[W-1-NIB_W*g -: NIB_W];
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(NIBS));
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0);
  assert_consume_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    consume <= cnt);
endmodule

// File: rtl/ins_decode.sv
module ins_decode
  import unpk_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [HEAD_W-1:0] head,
  input  logic [CW-1:0]     cnt,
  output logic              complete,
  output logic [LEN_W-1:0]  len,
  output iclass_t           cls,
  output logic [3:0]        op,
  output logic [WORD_W-1:0] operand
);
  logic [3:0] n0, n1, n2, n3, n4, n5;
  assign {n0, n1, n2, n3, n4, n5} = head;

  always_comb begin
    len     = LEN_W'(1);
    cls     = CL_SHORT;
    op      = n0;
    operand = '0;
    if (n0 <= CODE_SHORT_LAST) begin
      len = LEN_W'(1);
    end else if (n0 == CODE_EXT) begin
      len = LEN_W'(2);
      cls = CL_EXT;
      op  = n1;
    end else if (n0 <= CODE_ADDR_LAST) begin
      len     = LEN_W'(3);
      cls     = CL_ADDR;
      op      = n0 - CODE_ADDR_FIRST;
      operand = {8'h00, n1, n2};
    end else if (n0 == CODE_LIT) begin
      len     = LEN_W'(3);
      cls     = CL_LIT;
      op      = 4'h0;
      operand = {8'h00, n1, n2} - LIT_BIAS;
    end else begin
      len     = LEN_W'(MAX_LEN);
      operand = {n2, n3, n4, n5};
      if (n1 <= LONG_ADDR_LAST) begin
        cls = CL_ADDR;
        op  = n1;
      end else begin
        cls = CL_LIT;
        op  = 4'h0;
      end
    end
    complete = cnt >= CW'(len);
  end
endmodule

// File: rtl/instr_unpacker.sv
module instr_unpacker
  import unpk_pkg::*;
#(
  parameter int WIN_WORDS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] word_in,
  input  logic        word_valid,
  output logic        word_ready,
  input  logic        restart,
  input  logic [1:0]  restart_nib,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_class,
  output logic [3:0]  out_op,
  output logic [15:0] out_operand
);
  localparam int NIBS = WIN_WORDS * NPW;
  localparam int CW   = $clog2(NIBS + 1);

  logic [CW-1:0]     cnt, consume;
  logic [HEAD_W-1:0] head;
  logic              complete, push;
  logic [LEN_W-1:0]  len;
  iclass_t           cls;

  assign word_ready = !restart && (cnt <= CW'(NIBS - NPW));
  assign push       = word_valid && word_ready;
  assign out_valid  = !restart && complete;
  assign consume    = (out_valid && out_ready) ? CW'(len) : '0;
  assign out_class  = cls;

  nib_window #(.WIN_WORDS(WIN_WORDS), .CW(CW)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (restart),
    .skip_in (restart_nib),
    .push    (push),
    .word    (word_in),
    .consume (consume),
    .cnt     (cnt),
    .head    (head)
  );

  ins_decode #(.CW(CW)) u_dec (
    .head     (head),
    .cnt      (cnt),
    .complete (complete),
    .len      (len),
    .cls      (cls),
    .op       (out_op),
    .operand  (out_operand)
  );

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (restart || (out_valid && $stable(out_class)
      && $stable(out_op) && $stable(out_operand))));
  assert_restart_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_valid);
  assert_short_no_operand_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'd0) |-> out_operand == 16'h0000);
endmodule

// File: tb/instr_unpacker_test.sv
`timescale 1ns/1ps
module instr_unpacker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word_in = '0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic        restart = 1'b0;
  logic [1:0]  restart_nib = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  out_class;
  logic [3:0]  out_op;
  logic [15:0] out_operand;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  instr_unpacker uut (.*);

  // Packed nibble stream: 5 93 A12 E00 EFF F2BEEF 0 E7F F71234 D34 8 BAB 9F 0 0 0
  localparam logic [15:0] WORDS [10] = '{16'h593A, 16'h12E0, 16'h0EFF, 16'hF2BE,
    16'hEF0E, 16'h7FF7, 16'h1234, 16'hD348, 16'hBAB9, 16'hF000};
  // {class, opcode, operand}
  localparam logic [21:0] EXP [16] = '{
    {2'd0, 4'h5, 16'h0000}, {2'd1, 4'h3, 16'h0000}, {2'd2, 4'h0, 16'h0012},
    {2'd3, 4'h0, 16'hFF81}, {2'd3, 4'h0, 16'h0080}, {2'd2, 4'h2, 16'hBEEF},
    {2'd0, 4'h0, 16'h0000}, {2'd3, 4'h0, 16'h0000}, {2'd3, 4'h0, 16'h1234},
    {2'd2, 4'h3, 16'h0034}, {2'd0, 4'h8, 16'h0000}, {2'd2, 4'h1, 16'h00AB},
    {2'd1, 4'hF, 16'h0000}, {2'd0, 4'h0, 16'h0000}, {2'd0, 4'h0, 16'h0000},
    {2'd0, 4'h0, 16'h0000}};
  localparam int TAGS [16] = '{2, 3, 4, 5, 5, 6, 2, 5, 6, 4, 2, 4, 3, 2, 2, 2};

  function automatic string tag_of(int k);
    case (k)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [21:0] outv();
    return {out_class, out_op, out_operand};
  endfunction

  task automatic send(logic [15:0] w);
    @(negedge clk);
    word_in = w;
    word_valid = 1'b1;
    #1;
    while (!word_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 word_valid = 1'b0;
  endtask

  task automatic pulse_ready();
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic do_restart(logic [1:0] nib);
    @(negedge clk);
    restart = 1'b1;
    restart_nib = nib;
    word_valid = 1'b1;
    word_in = 16'h1111;
    #1;
    chk("R10 word_ready during restart", 32'(word_ready), 32'd0);
    chk("R10 out_valid during restart", 32'(out_valid), 32'd0);
    @(posedge clk);
    #1 restart = 1'b0;
    word_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int iw;
    int io;
    logic [21:0] held;
    iw = 0;
    io = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 word_ready after reset", 32'(word_ready), 32'd1);

    // Table walk with gaps on both streams.
    for (int cyc = 0; cyc < 400 && io < 16; cyc++) begin
      @(negedge clk);
      word_valid = (iw < 10) && (cyc % 4 != 3);
      word_in = (iw < 10) ? WORDS[iw] : 16'h0000;
      out_ready = (cyc % 3 != 2);
      #1;
      if (out_valid && out_ready) begin
        chk(tag_of(TAGS[io]), 32'(outv()), 32'(EXP[io]));
        io++;
      end
      if (word_valid && word_ready) iw++;
    end
    @(negedge clk);
    word_valid = 1'b0;
    out_ready = 1'b0;
    #1;
    chk("R7 instructions delivered in order", 32'(io), 32'd16);
    chk("R7 nothing left after stream", 32'(out_valid), 32'd0);

    // Back-pressure and window fill: stream A,1,2,3,4,5,6,7,8,9,A,B.
    do_restart(2'd0);
    send(16'hA123);
    @(negedge clk);
    #1 held = outv();
    chk("R4 head while stalled", 32'(held), 32'({2'd2, 4'h0, 16'h0012}));
    send(16'h4567);
    send(16'h89AB);
    @(negedge clk);
    #1;
    chk("R8 output held under back-pressure", 32'(outv()), 32'(held));
    chk("R8 valid held under back-pressure", 32'(out_valid), 32'd1);
    chk("R9 window full 12 nibbles", 32'(word_ready), 32'd0);
    pulse_ready();
    @(negedge clk);
    #1;
    chk("R9 nine nibbles not ready", 32'(word_ready), 32'd0);
    chk("R2 next short op", 32'(outv()), 32'({2'd0, 4'h3, 16'h0000}));
    pulse_ready();
    @(negedge clk);
    #1;
    chk("R9 eight nibbles ready", 32'(word_ready), 32'd1);
    chk("R2 following short op", 32'(outv()), 32'({2'd0, 4'h4, 16'h0000}));

    // Incomplete long form waits; restart discards it and applies the offset.
    do_restart(2'd0);
    send(16'hF1AA);
    @(negedge clk);
    #1;
    chk("R6 long form incomplete", 32'(out_valid), 32'd0);
    do_restart(2'd2);
    send(16'h33E8);
    @(negedge clk);
    #1;
    chk("R10 two nibbles after offset", 32'(out_valid), 32'd0);
    send(16'h0000);
    @(negedge clk);
    #1;
    chk("R10 offset literal valid", 32'(out_valid), 32'd1);
    chk("R10 offset literal value", 32'(outv()), 32'({2'd3, 4'h0, 16'h0001}));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule